// File: doc/BRIEF.md
# Receive Burst and Loopback Router

This block stands between the message engine of a serial-bus remote terminal and a port into host memory. For every message the engine announces (subaddress, direction, word-count field), the router picks one of three ways to handle the data words. It can pass each word to the host at once. It can hold the received words in an internal FIFO and write them to the host as one unbroken burst after the message ends cleanly. It can also keep the words of subaddress 30 inside the FIFO so that a later transmit to subaddress 30 plays them back without touching the host.

The host side is a single-word request/acknowledge port, with a direction bit that selects a host-memory write or read. A word counts as moved only in a cycle in which request and acknowledge are both high. On the transmit side the router presents one word at a time to the engine, which consumes it with a take strobe. A protocol-revision input sets which subaddresses carry mode codes and how many data words a mode code has.

Top module: `rx_burst_loop_router`

## Requirements
- R1: After reset, host_req, tx_valid and wrap_underflow are low and the FIFO is empty, so a loopback transmit issued first returns only zero words.
- R2: With burst disabled, a receive message that is neither loopback nor mode code produces one host write (host_write=1) per accepted word, carrying that word, in arrival order.
- R3: With burst enabled, an ordinary receive message makes no host request while it runs. After msg_end with msg_err low, every accepted word is written to the host in order, and host_req stays high without a break from the first word to the last.
- R4: A burst or loopback receive message that ends with msg_err high causes no host transfer, and the FIFO is left empty.
- R5: With wraparound enabled, a receive message to subaddress 30 stores its words in the FIFO and makes no host request.
- R6: With wraparound enabled, a transmit message to subaddress 30 presents the stored words in order and makes no host request.
- R7: When a loopback transmit needs a word and the FIFO is empty, the router presents 0x0000 and sets wrap_underflow. The flag is cleared when the next message starts.
- R8: An ordinary transmit message fetches each word with a host read (host_write=0), and tx_data equals the host_rdata of that transfer.
- R9: For an ordinary subaddress, a word-count field of 0 means 32 words. Received words beyond the count are ignored, and a transmit presents exactly the count.
- R10: In revision-B mode (cfg_proto_b=1), subaddresses 0 and 31 are mode codes. They carry one data word when bit 4 of the code field is 1 and none otherwise, and that word always takes the direct path, never burst or loopback.
- R11: In revision-A mode (cfg_proto_b=0), subaddress 31 is an ordinary data subaddress. Subaddress 0 is a mode code that carries no data words, so its received words are ignored and its transmit presents none.
- R12: While host_req is high and host_ack is low, host_req, host_write and (for writes) host_wdata stay unchanged into the next cycle.
- R13: A receive message that uses the FIFO (burst or loopback) starts with the FIFO empty, so older loopback words are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_en | input | 1 | Hold ordinary received words for a burst after the message |
| cfg_wrap_en | input | 1 | Loop subaddress 30 through the FIFO |
| cfg_proto_b | input | 1 | 1 = revision-B mode-code rules, 0 = revision A |
| msg_start | input | 1 | One-cycle strobe: a new message begins, fields valid |
| msg_sa | input | 5 | Subaddress of the message |
| msg_tx | input | 1 | 1 = terminal transmits, 0 = terminal receives |
| msg_wc | input | 5 | Word-count field (mode code for mode-code subaddresses) |
| rx_valid | input | 1 | One-cycle strobe: a received data word is on rx_data |
| rx_data | input | 16 | Received data word |
| msg_end | input | 1 | One-cycle strobe: the message is over |
| msg_err | input | 1 | Qualifies msg_end: the message failed |
| tx_valid | output | 1 | A transmit word is presented |
| tx_data | output | 16 | Presented transmit word |
| tx_take | input | 1 | Engine consumes the presented word |
| wrap_underflow | output | 1 | A loopback transmit ran out of stored words |
| host_req | output | 1 | Host transfer request |
| host_write | output | 1 | 1 = write to host memory, 0 = read |
| host_wdata | output | 16 | Word written to the host |
| host_rdata | input | 16 | Word read from the host |
| host_ack | input | 1 | Host accepts the transfer this cycle |

## Verification
The assertions assume that the engine starts a message only when no host transfer, burst drain or read is outstanding. They also assume that in the direct receive path a word is acknowledged before the next one arrives, and that msg_start, rx_valid and msg_end never fall in the same cycle. The stimulus respects this: after every message it waits until host_req has been low for several cycles, and after every direct word it waits for the write to finish. Acknowledge is random, so stalls occur while the start and word-spacing rules still hold.

// File: rtl/rblr_pkg.sv
// Shared types for the burst and loopback router.
package rblr_pkg;
    // How the data words of the current message are handled.
    typedef enum logic [2:0] {
        RT_IDLE,   // no message, words ignored
        RT_DRX,    // receive, each word written to host at once
        RT_DTX,    // transmit, each word read from host
        RT_BRX,    // receive, held in FIFO for a burst
        RT_WRX,    // loopback receive into FIFO
        RT_WTX     // loopback transmit out of FIFO
    } route_e;
endpackage

// File: rtl/rblr_fifo.sv
// Word FIFO with synchronous flush.
// Assumes DEPTH is a power of two; flush overrides push and pop.
module rblr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full;

    assign dout  = mem[rp];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) (push && !flush) |-> !full);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (pop && !flush) |-> !empty);  // R6
endmodule

// File: rtl/rblr_classify.sv
// Decides the route and data-word count of a message from its command fields.
// Purely combinational; sampled by the top on msg_start.
module rblr_classify
    import rblr_pkg::*;
#(
    parameter int SA_W    = 5,
    parameter int WC_W    = 5,
    parameter int CNT_W   = 6,
    parameter int LOOP_SA = 30,
    parameter int MODE_SA = 31
) (
    input  logic [SA_W-1:0]  sa,
    input  logic             is_tx,
    input  logic [WC_W-1:0]  wc,
    input  logic             burst_en,
    input  logic             wrap_en,
    input  logic             proto_b,
    output route_e           route,
    output logic [CNT_W-1:0] n_words
);
    logic mode, loop;

    // Mode-code detection, word count and route choice.
    always_comb begin
        mode = (sa == '0) || (proto_b && sa == SA_W'(MODE_SA));
        loop = wrap_en && !mode && (sa == SA_W'(LOOP_SA));
        if (mode)
            n_words = (proto_b && wc[WC_W-1]) ? CNT_W'(1) : '0;
        else if (wc == '0)
            n_words = CNT_W'(1) << WC_W;
        else
            n_words = CNT_W'(wc);
        if (loop)
            route = is_tx ? RT_WTX : RT_WRX;
        else if (is_tx)
            route = RT_DTX;
        else if (burst_en && !mode)
            route = RT_BRX;
        else
            route = RT_DRX;
    end
endmodule

// File: rtl/rx_burst_loop_router.sv
// Routes data words of one message at a time between the message engine,
// an internal FIFO and a request/acknowledge host port.
// Assumes: msg_start only when no host transfer is outstanding; in the direct
// receive path a word is acknowledged before the next arrives; msg_start,
// rx_valid and msg_end never coincide.
module rx_burst_loop_router
    import rblr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 32,
    parameter int SA_W    = 5,
    parameter int LOOP_SA = 30,
    parameter int MODE_SA = 31,
    localparam int WC_W   = $clog2(DEPTH),
    localparam int CNT_W  = WC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_burst_en,
    input  logic              cfg_wrap_en,
    input  logic              cfg_proto_b,
    input  logic              msg_start,
    input  logic [SA_W-1:0]   msg_sa,
    input  logic              msg_tx,
    input  logic [WC_W-1:0]   msg_wc,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              msg_end,
    input  logic              msg_err,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_take,
    output logic              wrap_underflow,
    output logic              host_req,
    output logic              host_write,
    output logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] host_rdata,
    input  logic              host_ack
);
    route_e             cls_route, route_q;
    logic [CNT_W-1:0]   cls_n, left_q;
    logic               wr_pend_q, drain_q, rd_pend_q, txv_q, unf_q;
    logic [DATA_W-1:0]  wr_data_q, txd_q;

    logic               fifo_flush, fifo_push, fifo_pop, fifo_empty;
    logic [DATA_W-1:0]  fifo_dout;
    logic [CNT_W-1:0]   fifo_count;
    logic               rx_take, wtx_load, dtx_fill, rd_issue, fifo_rx;

    rblr_classify #(
        .SA_W(SA_W), .WC_W(WC_W), .CNT_W(CNT_W),
        .LOOP_SA(LOOP_SA), .MODE_SA(MODE_SA)
    ) u_classify (
        .sa(msg_sa), .is_tx(msg_tx), .wc(msg_wc),
        .burst_en(cfg_burst_en), .wrap_en(cfg_wrap_en), .proto_b(cfg_proto_b),
        .route(cls_route), .n_words(cls_n)
    );

    rblr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
        .push(fifo_push), .din(rx_data), .pop(fifo_pop),
        .dout(fifo_dout), .count(fifo_count), .empty(fifo_empty)
    );

    // Per-cycle word events derived from the current route.
    always_comb begin
        fifo_rx    = (route_q == RT_BRX) || (route_q == RT_WRX);
        rx_take    = rx_valid && (left_q != '0) &&
                     (fifo_rx || route_q == RT_DRX);
        wtx_load   = (route_q == RT_WTX) && (left_q != '0) && !txv_q;
        rd_issue   = (route_q == RT_DTX) && (left_q != '0) && !txv_q && !rd_pend_q;
        dtx_fill   = rd_pend_q && host_ack && (route_q == RT_DTX);
        fifo_push  = rx_take && fifo_rx;
        fifo_pop   = (drain_q && host_ack) || (wtx_load && !fifo_empty);
        fifo_flush = (msg_start && (cls_route == RT_BRX || cls_route == RT_WRX)) ||
                     (msg_end && msg_err && fifo_rx);
    end

    // Host port: one source active at a time.
    assign host_req   = wr_pend_q || drain_q || rd_pend_q;
    assign host_write = !rd_pend_q;
    assign host_wdata = drain_q ? fifo_dout : wr_data_q;
    assign tx_valid       = txv_q;
    assign tx_data        = txd_q;
    assign wrap_underflow = unf_q;

    // Message route and remaining-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= RT_IDLE;
            left_q  <= '0;
        end else if (msg_start) begin
            route_q <= cls_route;
            left_q  <= cls_n;
        end else if (msg_end) begin
            route_q <= RT_IDLE;
            left_q  <= '0;
        end else if (rx_take || wtx_load || dtx_fill) begin
            left_q  <= left_q - CNT_W'(1);
        end
    end

    // Direct receive: one-word holding register toward the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend_q <= 1'b0;
            wr_data_q <= '0;
        end else if (rx_take && route_q == RT_DRX) begin
            wr_pend_q <= 1'b1;
            wr_data_q <= rx_data;
        end else if (wr_pend_q && host_ack) begin
            wr_pend_q <= 1'b0;
        end
    end

    // Burst drain: request held until the FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_q <= 1'b0;
        else if (msg_end && !msg_err && route_q == RT_BRX && !fifo_empty)
            drain_q <= 1'b1;
        else if (drain_q && host_ack && fifo_count == CNT_W'(1))
            drain_q <= 1'b0;
    end

    // Direct transmit: host read outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_pend_q <= 1'b0;
        else if (rd_issue)
            rd_pend_q <= 1'b1;
        else if (rd_pend_q && host_ack)
            rd_pend_q <= 1'b0;
    end

    // Transmit word register toward the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txv_q <= 1'b0;
            txd_q <= '0;
        end else if (msg_start || msg_end) begin
            txv_q <= 1'b0;
        end else if (tx_take && txv_q) begin
            txv_q <= 1'b0;
        end else if (wtx_load) begin
            txv_q <= 1'b1;
            txd_q <= fifo_empty ? '0 : fifo_dout;
        end else if (dtx_fill) begin
            txv_q <= 1'b1;
            txd_q <= host_rdata;
        end
    end

    // Loopback underflow flag, cleared per message.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unf_q <= 1'b0;
        else if (msg_start)
            unf_q <= 1'b0;
        else if (wtx_load && fifo_empty)
            unf_q <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> (host_req && $stable(host_write) && (!host_write || $stable(host_wdata))));  // R12
    AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q && !(host_ack && fifo_count == CNT_W'(1))) |=> host_req);  // R3
    AST_BURST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == RT_BRX) |-> !host_req);  // R3
    AST_LOOP_NO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == RT_WRX || route_q == RT_WTX) |-> !host_req);  // R5
    AST_UNF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_underflow) |-> $past(route_q == RT_WTX));  // R7
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |-> (!drain_q && !wr_pend_q && !rd_pend_q));  // R13
    AST_NO_WR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && route_q == RT_DRX) |-> (!wr_pend_q || host_ack));  // R2
endmodule

// File: tb/rx_burst_loop_router_tb.sv
`timescale 1ns/1ps
module rx_burst_loop_router_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_burst_en = 0, cfg_wrap_en = 0, cfg_proto_b = 1;
    logic msg_start = 0, msg_tx = 0, rx_valid = 0, msg_end = 0, msg_err = 0, tx_take = 0;
    logic [4:0] msg_sa = 0, msg_wc = 0;
    logic [15:0] rx_data = 0, host_rdata = 0;
    logic host_ack = 0;
    logic tx_valid, wrap_underflow, host_req, host_write;
    logic [15:0] tx_data, host_wdata;

    int n_chk = 0, n_fail = 0;
    logic [15:0] wlog [0:63];
    logic [15:0] rlog [0:63];
    int wlog_n = 0, rlog_n = 0, gaps = 0, gap_exp = 0, rd_seq = 0;
    logic [15:0] mdl [0:31];
    int mdl_n = 0;

    always #4 clk = ~clk;

    rx_burst_loop_router u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_mode(input bit pb, input logic [4:0] sa);
        return (sa == 0) || (pb && sa == 31);
    endfunction

    function automatic int exp_words(input bit pb, input logic [4:0] sa, input logic [4:0] wc);
        if (is_mode(pb, sa)) return (pb && wc[4]) ? 1 : 0;
        return (wc == 0) ? 32 : int'(wc);
    endfunction

    // Host model: random acknowledge, transfer log, stall and gap checks.
    initial begin
        bit stall_prev = 0, prev_w = 0;
        logic [15:0] prev_d = 0;
        forever begin
            @(negedge clk);
            host_ack   = ($urandom % 4) != 0;
            host_rdata = 16'hA000 ^ 16'(rd_seq * 37);
            #1;
            if (stall_prev)
                chk(host_req && host_write == prev_w && (!prev_w || host_wdata == prev_d),
                    "R12", "stalled request changed", int'(host_wdata), int'(prev_d));
            if (host_req && host_ack) begin
                if (host_write) begin
                    if (wlog_n < 64) wlog[wlog_n] = host_wdata;
                    wlog_n++;
                end else begin
                    if (rlog_n < 64) rlog[rlog_n] = host_rdata;
                    rlog_n++;
                    rd_seq++;
                end
            end
            if (!host_req && wlog_n > 0 && wlog_n < gap_exp) gaps++;
            stall_prev = host_req && !host_ack;
            prev_w = host_write;
            prev_d = host_wdata;
        end
    end

    task automatic wait_idle(input int quiet);
        int q = 0, t = 0;
        while (q < quiet && t < 3000) begin
            @(negedge clk);
            q = host_req ? 0 : q + 1;
            t++;
        end
    endtask

    task automatic run_msg(input bit pb, input bit be, input bit we, input logic [4:0] sa,
                           input bit tx, input logic [4:0] wc, input int extra, input bit err);
        int n, k, got, exp_w;
        bit mode, loop, bur, exp_unf;
        logic [15:0] words [0:39];
        string tg;
        n    = exp_words(pb, sa, wc);
        mode = is_mode(pb, sa);
        loop = we && !mode && sa == 30;
        bur  = be && !tx && !loop && !mode;
        tg   = bur ? "R3" : loop ? (tx ? "R6" : "R5") : mode ? (pb ? "R10" : "R11") : (tx ? "R8" : "R2");
        @(negedge clk);
        cfg_proto_b = pb; cfg_burst_en = be; cfg_wrap_en = we;
        msg_sa = sa; msg_tx = tx; msg_wc = wc; msg_start = 1;
        wlog_n = 0; rlog_n = 0; gaps = 0; gap_exp = 0;
        @(negedge clk);
        msg_start = 0;
        chk(wrap_underflow == 0, "R7", "flag not cleared at start", int'(wrap_underflow), 0);
        if (!tx) begin
            if (loop || bur) mdl_n = 0;  // R13
            k = err ? ((n > 0) ? n - 1 : 0) : n + extra;
            exp_w = (k < n) ? k : n;
            if (bur) gap_exp = err ? 0 : exp_w;
            for (int i = 0; i < k; i++) begin
                words[i] = 16'($urandom);
                @(negedge clk);
                rx_valid = 1; rx_data = words[i];
                @(negedge clk);
                rx_valid = 0;
                wait_idle(1);
            end
            @(negedge clk);
            msg_end = 1; msg_err = err;
            @(negedge clk);
            msg_end = 0; msg_err = 0;
            wait_idle(4);
            if (loop && !err) begin
                for (int i = 0; i < exp_w; i++) mdl[i] = words[i];
                mdl_n = exp_w;
            end
            if (loop || (bur && err)) exp_w = 0;
            chk(wlog_n == exp_w, err ? "R4" : (extra > 0 ? "R9" : tg), "host write count", wlog_n, exp_w);
            for (int i = 0; i < exp_w && i < wlog_n; i++)
                chk(wlog[i] == words[i], tg, "host write data", int'(wlog[i]), int'(words[i]));
            if (bur && exp_w > 0)
                chk(gaps == 0, "R3", "burst request gaps", gaps, 0);
        end else begin
            logic [15:0] seen [0:31];
            int rd = 0;
            exp_unf = loop && (n > mdl_n);
            for (int i = 0; i < n; i++) begin
                int t = 0;
                while (!tx_valid && t < 400) begin @(negedge clk); t++; end
                seen[i] = tx_data;
                tx_take = 1;
                @(negedge clk);
                tx_take = 0;
            end
            repeat (6) @(negedge clk);
            chk(tx_valid == 0, "R9", "extra transmit word", int'(tx_valid), 0);
            chk(wrap_underflow == exp_unf, "R7", "underflow flag", int'(wrap_underflow), int'(exp_unf));
            if (loop) begin
                chk(rlog_n == 0, "R6", "host reads in loopback", rlog_n, 0);
                for (int i = 0; i < n; i++) begin
                    logic [15:0] e;
                    e = (rd < mdl_n) ? mdl[rd] : 16'h0000;
                    rd++;
                    chk(seen[i] == e, (e == 0 && rd > mdl_n) ? "R7" : "R6", "loopback word", int'(seen[i]), int'(e));
                end
                for (int i = 0; i + rd < mdl_n; i++) mdl[i] = mdl[i + rd];
                mdl_n = (rd < mdl_n) ? mdl_n - rd : 0;
            end else begin
                chk(rlog_n == n, tg, "host read count", rlog_n, n);
                for (int i = 0; i < n && i < rlog_n; i++)
                    chk(seen[i] == rlog[i], "R8", "transmit word", int'(seen[i]), int'(rlog[i]));
            end
            @(negedge clk);
            msg_end = 1;
            @(negedge clk);
            msg_end = 0;
            wait_idle(4);
        end
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(host_req == 0 && tx_valid == 0 && wrap_underflow == 0, "R1", "outputs after reset",
            {host_req, tx_valid, wrap_underflow}, 0);
        run_msg(1, 0, 1, 30, 1, 2, 0, 0);    // R1 empty FIFO -> zeros, R7
        run_msg(1, 1, 0, 5, 0, 0, 2, 0);     // R3 burst of 32, R9
        run_msg(1, 0, 1, 30, 0, 3, 0, 0);    // R5
        run_msg(1, 0, 1, 30, 1, 5, 0, 0);    // R6 three words then R7 zeros
        run_msg(1, 0, 1, 30, 0, 4, 0, 1);    // R4 loopback error
        run_msg(1, 0, 1, 30, 1, 2, 0, 0);    // R4 FIFO left empty
        run_msg(1, 1, 0, 9, 0, 6, 0, 1);     // R4 burst error
        run_msg(1, 1, 1, 30, 0, 4, 0, 0);
        run_msg(1, 1, 1, 12, 0, 2, 0, 0);    // R13 burst discards loop words
        run_msg(1, 1, 1, 30, 1, 1, 0, 0);
        run_msg(1, 1, 1, 31, 0, 17, 1, 0);   // R10 one word, direct
        run_msg(1, 1, 0, 31, 0, 5, 1, 0);    // R10 no word
        run_msg(1, 0, 0, 0, 1, 18, 0, 0);    // R10 mode transmit one word
        run_msg(0, 0, 0, 0, 0, 18, 2, 0);    // R11 ignored words
        run_msg(0, 0, 0, 0, 1, 18, 0, 0);    // R11 no transmit words
        run_msg(0, 1, 0, 31, 0, 2, 0, 0);    // R11 ordinary, bursted
        run_msg(1, 0, 0, 7, 1, 4, 0, 0);     // R8
        run_msg(1, 0, 0, 3, 0, 2, 2, 0);     // R2 with extras, R9
        for (int it = 0; it < 40; it++) begin
            int r;
            logic [4:0] sa;
            bit tx;
            r  = $urandom % 8;
            sa = (r == 0) ? 5'd0 : (r == 1) ? 5'd31 : (r < 4) ? 5'd30 : 5'(1 + $urandom % 29);
            tx = $urandom % 2;
            run_msg(($urandom % 4) != 0, $urandom % 2, $urandom % 2, sa, tx,
                    5'($urandom % 32), $urandom % 3, !tx && ($urandom % 6 == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule